// File: doc/BRIEF.md
# E1 CAS Signaling Change Detector

This block watches the channel-associated signaling carried in timeslot 16 of an E1 stream. It receives one timeslot-16 byte per frame, together with that frame's number inside the 16-frame CAS multiframe. It gathers the ABCD nibbles of all 30 voice channels in a shadow buffer. When the last frame of the multiframe arrives, it commits the whole set at once. The committed set is compared with the signaling state held for each channel, and any channel whose state moves is flagged.

A single global integration control adds a persistence filter. With it on, a new nibble is taken only once it has been seen, unchanged, in three consecutive multiframes. Short glitches never reach the stored state or the status bits.

Each channel has a sticky change bit that records every accepted change. Each channel also has an enable bit, and only enabled channels can set the latched summary flag. The summary flag drives an active-low interrupt when the interrupt enable is set. A small register interface gives read access and write-one-to-clear for the sticky bits.

Top module: `e1cas_sig_detect`

## Requirements
- R1: The byte of frame f (1 to 15) carries channel f in bits [7:4] and channel f+15 in bits [3:0], with channels numbered 1 to 30. The byte of frame 0 is ignored.
- R2: Stored channel states change only at the commit that follows the frame-15 byte, never mid-multiframe. Channel i (0-based index, channel number minus one) reads at address 8 + i/8, bits [4*(i%8)+3 : 4*(i%8)].
- R3: The first multiframe after reset loads every channel's state and reports no change.
- R4: With integration off (control bit 0 = 0), a committed nibble that differs from the stored state replaces it and sets that channel's status bit. A nibble equal to the stored state sets nothing.
- R5: With integration on, a differing nibble is accepted and reported only after three consecutive multiframes with the same value. The persistence count restarts whenever the incoming nibble differs from the pending candidate or returns to the stored state.
- R6: The status bit of a channel (address 2, bit i) is set on every accepted change, whatever its enable bit (address 1, bit i). The summary flag (address 3, bit 0) is set only by changes on enabled channels.
- R7: Writing 1 to a status bit or to the summary bit clears it. A change arriving in the same cycle as the clear wins, and the bit stays set.
- R8: int_n is low exactly when the summary flag is set and the interrupt enable (address 0, bit 1) is 1.
- R9: After reset all registers read zero and int_n is high.
- R10: Integration is one global bit (address 0, bit 0) that applies to every channel at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ts_valid | input | 1 | Timeslot-16 byte present this cycle |
| ts_frame | input | 4 | Frame number within the multiframe (0 to 15) |
| ts_byte | input | 8 | Timeslot-16 byte |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 4 | Register address |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Register read data, combinational from host_addr |
| int_n | output | 1 | Active-low change-of-state interrupt |

## Verification
The checker watches several properties on every cycle:
- stored channel states move only in the cycle after a commit;
- change pulses follow commits and never come from the loading multiframe;
- sticky bits fall only after a status write;
- enabled changes always raise the summary;
- int_n stays high without a summary.

Other behaviour needs directed scenarios to show it. These cover the exact nibble-to-channel mapping, the three-multiframe acceptance, the restart of the persistence count, the masking of the summary, and the set-over-clear race. The bench drives them through the ports and reads the results back through the register interface.

// File: rtl/e1cas_pkg.sv
package e1cas_pkg;
  localparam int NUM_CH      = 30;
  localparam int HALF_CH     = NUM_CH / 2;
  localparam int NIB_W       = 4;
  localparam int MF_FRAMES   = 16;
  localparam int FRAME_W     = $clog2(MF_FRAMES);
  localparam int BYTE_W      = 2 * NIB_W;
  localparam int INTEG_LEN   = 3;
  localparam int CNT_W       = $clog2(INTEG_LEN);
  localparam int ADDR_W      = 4;
  localparam int DATA_W      = 32;
  localparam int CH_PER_WORD = DATA_W / NIB_W;
  localparam int SIG_WORDS   = (NUM_CH + CH_PER_WORD - 1) / CH_PER_WORD;
  localparam int SIG_BITS    = NUM_CH * NIB_W;

  localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
  localparam logic [ADDR_W-1:0] A_MASK = 4'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 4'd2;
  localparam logic [ADDR_W-1:0] A_SUM  = 4'd3;
  localparam int                A_SIG  = 8;

  localparam int CTRL_INTEG = 0;
  localparam int CTRL_IRQEN = 1;
endpackage

// File: rtl/e1cas_rst_sync.sv
module e1cas_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_s = sync_q[1];
endmodule

// File: rtl/e1cas_capture.sv
module e1cas_capture
  import e1cas_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ts_valid,
  input  logic [FRAME_W-1:0]  ts_frame,
  input  logic [BYTE_W-1:0]   ts_byte,
  output logic                mf_stb,
  output logic                primed,
  output logic [SIG_BITS-1:0] mf_sig
);
  logic [SIG_BITS-1:0] shad_q, shad_d;
  logic                stb_q, stb_d;
  logic                primed_q, primed_d;
  logic                wr_en, commit;
  int                  base;

  assign wr_en  = ts_valid && (ts_frame != '0);
  assign commit = ts_valid && (ts_frame == FRAME_W'(MF_FRAMES - 1));

  always_comb begin
    shad_d = shad_q;
    base   = int'(ts_frame) - 1;
    if (wr_en) begin
      shad_d[base*NIB_W +: NIB_W]             = ts_byte[BYTE_W-1:NIB_W];
      shad_d[(base+HALF_CH)*NIB_W +: NIB_W]   = ts_byte[NIB_W-1:0];
    end
    stb_d    = commit;
    primed_d = primed_q | stb_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shad_q   <= '0;
      stb_q    <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      stb_q    <= stb_d;
      primed_q <= primed_d;
      if (wr_en) shad_q <= shad_d;
    end
  end

  assign mf_stb = stb_q;
  assign primed = primed_q;
  assign mf_sig = shad_q;
endmodule

// File: rtl/e1cas_chan_filter.sv
module e1cas_chan_filter
  import e1cas_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mf_stb,
  input  logic             primed,
  input  logic             integ_en,
  input  logic [NIB_W-1:0] sig_in,
  output logic [NIB_W-1:0] sig_cur,
  output logic             chg
);
  logic [NIB_W-1:0] cur_q, cur_d, cand_q, cand_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             chg_q, chg_d;

  always_comb begin
    cur_d  = cur_q;
    cand_d = cand_q;
    cnt_d  = cnt_q;
    chg_d  = 1'b0;
    if (mf_stb) begin
      if (!primed) begin
        cur_d  = sig_in;
        cand_d = sig_in;
        cnt_d  = '0;
      end else if (!integ_en) begin
        cand_d = sig_in;
        cnt_d  = '0;
        if (sig_in != cur_q) begin
          cur_d = sig_in;
          chg_d = 1'b1;
        end
      end else if (sig_in == cur_q) begin
        cand_d = sig_in;
        cnt_d  = '0;
      end else if (sig_in != cand_q) begin
        cand_d = sig_in;
        cnt_d  = CNT_W'(1);
      end else if (cnt_q == CNT_W'(INTEG_LEN - 1)) begin
        cur_d = sig_in;
        cnt_d = '0;
        chg_d = 1'b1;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      cand_q <= '0;
      cnt_q  <= '0;
      chg_q  <= 1'b0;
    end else begin
      chg_q <= chg_d;
      if (mf_stb) begin
        cur_q  <= cur_d;
        cand_q <= cand_d;
        cnt_q  <= cnt_d;
      end
    end
  end

  assign sig_cur = cur_q;
  assign chg     = chg_q;
endmodule

// File: rtl/e1cas_host.sv
module e1cas_host
  import e1cas_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_wr,
  input  logic [ADDR_W-1:0]   host_addr,
  input  logic [DATA_W-1:0]   host_wdata,
  input  logic [NUM_CH-1:0]   chg,
  input  logic [SIG_BITS-1:0] sig_cur,
  output logic [DATA_W-1:0]   host_rdata,
  output logic                integ_en,
  output logic [NUM_CH-1:0]   en_vec,
  output logic [NUM_CH-1:0]   stat_vec,
  output logic                sum_flag,
  output logic                int_n
);
  logic [1:0]        ctrl_q, ctrl_d;
  logic [NUM_CH-1:0] en_q, en_d, stat_q, stat_d, clr_stat;
  logic              sum_q, sum_d, clr_sum;
  logic              wr_ctrl, wr_mask, wr_stat, wr_sum;
  int                word, ch;

  assign wr_ctrl = host_wr && (host_addr == A_CTRL);
  assign wr_mask = host_wr && (host_addr == A_MASK);
  assign wr_stat = host_wr && (host_addr == A_STAT);
  assign wr_sum  = host_wr && (host_addr == A_SUM);

  always_comb begin
    ctrl_d   = wr_ctrl ? host_wdata[1:0] : ctrl_q;
    en_d     = wr_mask ? host_wdata[NUM_CH-1:0] : en_q;
    clr_stat = wr_stat ? host_wdata[NUM_CH-1:0] : '0;
    clr_sum  = wr_sum && host_wdata[0];
    stat_d   = (stat_q & ~clr_stat) | chg;
    sum_d    = (sum_q & ~clr_sum) | (|(chg & en_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      en_q   <= '0;
      stat_q <= '0;
      sum_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      sum_q  <= sum_d;
      if (wr_ctrl) ctrl_q <= ctrl_d;
      if (wr_mask) en_q   <= en_d;
    end
  end

  always_comb begin
    host_rdata = '0;
    word       = int'(host_addr) - A_SIG;
    ch         = 0;
    case (host_addr)
      A_CTRL:  host_rdata[1:0]        = ctrl_q;
      A_MASK:  host_rdata[NUM_CH-1:0] = en_q;
      A_STAT:  host_rdata[NUM_CH-1:0] = stat_q;
      A_SUM:   host_rdata[0]          = sum_q;
      default: begin
        if (word >= 0 && word < SIG_WORDS) begin
          for (int j = 0; j < CH_PER_WORD; j++) begin
            ch = word * CH_PER_WORD + j;
            if (ch < NUM_CH)
              host_rdata[j*NIB_W +: NIB_W] = sig_cur[ch*NIB_W +: NIB_W];
          end
        end
      end
    endcase
  end

  assign integ_en = ctrl_q[CTRL_INTEG];
  assign en_vec   = en_q;
  assign stat_vec = stat_q;
  assign sum_flag = sum_q;
  assign int_n    = ~(sum_q & ctrl_q[CTRL_IRQEN]);
endmodule

// File: rtl/e1cas_sig_detect.sv
module e1cas_sig_detect
  import e1cas_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ts_valid,
  input  logic [FRAME_W-1:0] ts_frame,
  input  logic [BYTE_W-1:0]  ts_byte,
  input  logic               host_wr,
  input  logic [ADDR_W-1:0]  host_addr,
  input  logic [DATA_W-1:0]  host_wdata,
  output logic [DATA_W-1:0]  host_rdata,
  output logic               int_n
);
  logic                rst_n_s;
  logic                mf_stb, primed, integ_en, sum_flag;
  logic [SIG_BITS-1:0] mf_sig, sig_cur;
  logic [NUM_CH-1:0]   chg, en_vec, stat_vec;

  e1cas_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  e1cas_capture u_cap (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .ts_valid (ts_valid),
    .ts_frame (ts_frame),
    .ts_byte  (ts_byte),
    .mf_stb   (mf_stb),
    .primed   (primed),
    .mf_sig   (mf_sig)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    e1cas_chan_filter u_flt (
      .clk      (clk),
      .rst_n    (rst_n_s),
      .mf_stb   (mf_stb),
      .primed   (primed),
      .integ_en (integ_en),
      .sig_in   (mf_sig[g*NIB_W +: NIB_W]),
      .sig_cur  (sig_cur[g*NIB_W +: NIB_W]),
      .chg      (chg[g])
    );
  end

  e1cas_host u_host (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .chg        (chg),
    .sig_cur    (sig_cur),
    .host_rdata (host_rdata),
    .integ_en   (integ_en),
    .en_vec     (en_vec),
    .stat_vec   (stat_vec),
    .sum_flag   (sum_flag),
    .int_n      (int_n)
  );
endmodule

// File: rtl/e1cas_checker.sv
module e1cas_checker
  import e1cas_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                mf_stb,
  input logic                primed,
  input logic [NUM_CH-1:0]   chg,
  input logic [SIG_BITS-1:0] sig_cur,
  input logic [NUM_CH-1:0]   stat,
  input logic [NUM_CH-1:0]   en,
  input logic                sum,
  input logic                host_wr,
  input logic [ADDR_W-1:0]   host_addr,
  input logic                int_n
);
  assert_state_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(mf_stb) |-> $stable(sig_cur));

  assert_no_report_on_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (chg != '0) |-> $past(primed));

  assert_change_at_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (chg != '0) |-> $past(mf_stb));

  assert_status_records_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (chg != '0) |=> ((stat & $past(chg)) == $past(chg)));

  assert_summary_from_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((chg & en) != '0) |=> sum);

  assert_sticky_until_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(stat) & ~stat) != '0) |-> $past(host_wr && host_addr == A_STAT));

  assert_irq_needs_summary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sum |-> int_n);
endmodule

bind e1cas_sig_detect e1cas_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .mf_stb    (mf_stb),
  .primed    (primed),
  .chg       (chg),
  .sig_cur   (sig_cur),
  .stat      (stat_vec),
  .en        (en_vec),
  .sum       (sum_flag),
  .host_wr   (host_wr),
  .host_addr (host_addr),
  .int_n     (int_n)
);

// File: tb/e1cas_sig_detect_tb.sv
module e1cas_sig_detect_tb;
  logic        clk;
  logic        rst_n;
  logic        ts_valid;
  logic [3:0]  ts_frame;
  logic [7:0]  ts_byte;
  logic        host_wr;
  logic [3:0]  host_addr;
  logic [31:0] host_wdata;
  logic [31:0] host_rdata;
  logic        int_n;

  int          n_chk = 0;
  int          n_fail = 0;
  logic [3:0]  model [30];
  logic [31:0] rv, ref_w;
  bit          done = 0;

  // row: {ch[4:0], new value[3:0], integ, expect change, expected stored value[3:0]}
  localparam logic [14:0] VEC [12] = '{
    {5'd0,  4'h3, 1'b0, 1'b1, 4'h3},
    {5'd29, 4'hF, 1'b0, 1'b1, 4'hF},
    {5'd14, 4'h2, 1'b0, 1'b0, 4'h2},
    {5'd5,  4'hC, 1'b1, 1'b0, 4'h3},
    {5'd5,  4'hC, 1'b1, 1'b0, 4'h3},
    {5'd5,  4'hC, 1'b1, 1'b1, 4'hC},
    {5'd7,  4'h6, 1'b1, 1'b0, 4'h1},
    {5'd7,  4'h6, 1'b1, 1'b0, 4'h1},
    {5'd7,  4'h1, 1'b1, 1'b0, 4'h1},
    {5'd7,  4'h6, 1'b1, 1'b0, 4'h1},
    {5'd7,  4'h1, 1'b0, 1'b0, 4'h1},
    {5'd20, 4'h0, 1'b0, 1'b1, 4'h0}
  };

  e1cas_sig_detect u_dut (
    .clk(clk), .rst_n(rst_n), .ts_valid(ts_valid), .ts_frame(ts_frame),
    .ts_byte(ts_byte), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .int_n(int_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic send_frame(input int f);
    @(negedge clk);
    ts_valid = 1'b1;
    ts_frame = 4'(f);
    ts_byte  = (f == 0) ? 8'hFF : {model[f-1], model[f+14]};
  endtask

  task automatic send_mf();
    for (int f = 0; f < 16; f++) send_frame(f);
    @(negedge clk) ts_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [31:0] exp_word(input int k);
    logic [31:0] w = '0;
    for (int j = 0; j < 8; j++)
      if (k*8 + j < 30) w[j*4 +: 4] = model[k*8 + j];
    return w;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ts_valid = 1'b0; ts_frame = '0; ts_byte = '0;
    host_wr = 1'b0; host_addr = '0; host_wdata = '0;
    for (int i = 0; i < 30; i++) model[i] = 4'((i * 7) % 16);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R9: reset state
    chk(int_n === 1'b1, "R9 int_n after reset", {31'd0, int_n}, 32'd1);
    rd(4'd2, rv); chk(rv === 32'd0, "R9 status after reset", rv, 32'd0);
    rd(4'd3, rv); chk(rv === 32'd0, "R9 summary after reset", rv, 32'd0);
    rd(4'd8, rv); chk(rv === 32'd0, "R9 state after reset", rv, 32'd0);

    // R3 and R1: first multiframe loads, frame 0 byte ignored
    wr(4'd1, 32'h3FFF_FFFF);
    send_mf();
    rd(4'd2, rv); chk(rv === 32'd0, "R3 no change on load", rv, 32'd0);
    for (int k = 0; k < 4; k++) begin
      rd(4'(8 + k), rv);
      chk(rv === exp_word(k), "R1 channel mapping", rv, exp_word(k));
    end

    // Vector table: R4, R5, R10
    for (int r = 0; r < 12; r++) begin
      int          ch;
      logic [31:0] w;
      ch = int'(VEC[r][14:10]);
      wr(4'd2, 32'hFFFF_FFFF);
      wr(4'd3, 32'd1);
      wr(4'd0, {31'd0, VEC[r][5]});
      model[ch] = VEC[r][9:6];
      send_mf();
      rd(4'd2, rv);
      chk(rv[ch] === VEC[r][4], VEC[r][5] ? "R5 R10 integrated change bit" : "R4 change bit",
          {31'd0, rv[ch]}, {31'd0, VEC[r][4]});
      rd(4'(8 + ch / 8), w);
      chk(w[(ch % 8)*4 +: 4] === VEC[r][3:0], VEC[r][5] ? "R5 stored value" : "R4 stored value",
          {28'd0, w[(ch % 8)*4 +: 4]}, {28'd0, VEC[r][3:0]});
    end

    // R2: no update mid-multiframe
    wr(4'd0, 32'd0);
    rd(4'd8, ref_w);
    chk(ref_w === exp_word(0), "R2 state before update", ref_w, exp_word(0));
    model[0] = 4'h9;
    for (int f = 0; f < 15; f++) send_frame(f);
    @(negedge clk) ts_valid = 1'b0;
    repeat (3) @(negedge clk);
    rd(4'd8, rv); chk(rv === ref_w, "R2 held mid-multiframe", rv, ref_w);
    send_frame(15);
    @(negedge clk) ts_valid = 1'b0;
    repeat (3) @(negedge clk);
    rd(4'd8, rv); chk(rv === exp_word(0), "R2 updated at commit", rv, exp_word(0));

    // R6: masked channel records status but no summary
    wr(4'd2, 32'hFFFF_FFFF);
    wr(4'd3, 32'd1);
    wr(4'd1, 32'h3FFF_FFFB);
    model[2] = ~model[2];
    send_mf();
    rd(4'd2, rv); chk(rv === 32'h4, "R6 masked channel status", rv, 32'h4);
    rd(4'd3, rv); chk(rv === 32'd0, "R6 masked channel no summary", rv, 32'd0);
    chk(int_n === 1'b1, "R8 int_n high without summary", {31'd0, int_n}, 32'd1);
    wr(4'd0, 32'd2);
    chk(int_n === 1'b1, "R8 enabled but no summary", {31'd0, int_n}, 32'd1);
    model[3] = ~model[3];
    send_mf();
    rd(4'd3, rv); chk(rv === 32'd1, "R6 enabled channel summary", rv, 32'd1);
    chk(int_n === 1'b0, "R8 int_n asserted", {31'd0, int_n}, 32'd0);
    wr(4'd0, 32'd0);
    chk(int_n === 1'b1, "R8 interrupt masked", {31'd0, int_n}, 32'd1);
    wr(4'd0, 32'd2);

    // R7: write-one-to-clear summary
    wr(4'd3, 32'd1);
    rd(4'd3, rv); chk(rv === 32'd0, "R7 summary cleared", rv, 32'd0);
    chk(int_n === 1'b1, "R7 int_n released", {31'd0, int_n}, 32'd1);

    // R7: set wins over clear in the same cycle (bits 2 and 3 set now)
    model[3] = ~model[3];
    for (int f = 0; f < 15; f++) send_frame(f);
    send_frame(15);
    @(negedge clk) ts_valid = 1'b0;
    @(negedge clk);
    host_wr = 1'b1; host_addr = 4'd2; host_wdata = 32'hFFFF_FFFF;
    @(negedge clk) host_wr = 1'b0;
    repeat (2) @(negedge clk);
    rd(4'd2, rv); chk(rv === 32'h8, "R7 set beats clear", rv, 32'h8);
    rd(4'd3, rv); chk(rv === 32'd1, "R7 summary reset by new change", rv, 32'd1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule